// File: doc/BRIEF.md
# Nonvolatile Block Range Guard

This block decides, for each program or erase request aimed at one of several 64 KB nonvolatile blocks, whether the request must be refused because it touches protected space. Every block owns a one-byte guard setting. The setting holds a master open bit and two regions that can be sized and switched off on their own. The low region starts at relative address 0x8000 and grows toward higher addresses. The high region ends at 0xFFFF and grows toward lower addresses.

At reset each guard setting is loaded from its own configuration byte. Here that load is a strobe that carries a slot number and a data byte. Slots and blocks run in opposite directions: slot 0 feeds the highest-numbered block. A command sequencer presents a block number, an operation code and a relative address. One clock later it receives a done pulse and a refuse bit. The flash array is not part of this block.

Top module: `nvm_range_guard`

## Requirements
- R1: Out of reset, `chk_done` and `chk_viol` are 0 and every guard setting reads as all zeros, so every block is fully locked until its setting is loaded.
- R2: `chk_done` is 1 exactly in the cycle after a cycle with `req_valid` = 1, and 0 otherwise. `chk_viol` is 0 whenever `chk_done` is 0.
- R3: A load with `cfg_slot` = s writes `cfg_byte` into the setting of block NUM_BLOCKS-1-s and leaves every other block unchanged. The byte layout is: bit 7 open (1 = programmable), bit 5 high-region off (1 = disabled), bits 4:3 high size code, bit 2 low-region off (1 = disabled), bits 1:0 low size code. Bit 6 has no effect.
- R4: When the open bit is 0, every operation on that block is refused, whatever the region fields hold and whatever the address is.
- R5: When the high region is enabled, it covers [0x10000 - S, 0xFFFF]. S is 2 KB, 4 KB, 8 KB or 16 KB for size codes 00, 01, 10 and 11. A program or sector erase inside it is refused. When the high region is disabled, it protects nothing.
- R6: When the low region is enabled, it covers [0x8000, 0x8000 + S). S is 512 B, 1 KB, 2 KB or 4 KB for size codes 00, 01, 10 and 11. A program or sector erase inside it is refused. When the low region is disabled, it protects nothing.
- R7: A word program (`req_op` = 00) is judged on the address with bit 0 cleared. A sector erase (`req_op` = 01) is judged on the 512-byte-aligned sector base.
- R8: A mass erase (`req_op` = 10) is refused when the block is locked or either region is enabled. It is allowed only when the block is open and both regions are off.
- R9: The undefined operation code 11 is always refused.
- R10: When a load and a request target the same block in the same cycle, the request is judged on the setting held before the load. The new setting applies from the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Load strobe for one guard setting |
| cfg_slot | input | BLK_W | Configuration byte slot (slot s feeds block NUM_BLOCKS-1-s) |
| cfg_byte | input | 8 | Guard setting byte |
| req_valid | input | 1 | Request strobe |
| req_block | input | BLK_W | Target block number |
| req_op | input | 2 | 00 program, 01 sector erase, 10 mass erase, 11 undefined |
| req_addr | input | ADDR_W | Relative target address inside the block |
| chk_done | output | 1 | Result valid, one cycle after the request |
| chk_viol | output | 1 | Request refused (protection violation) |

## Verification
The load path and the check path can act in the same cycle. The reset-time setting load may land on the block that a request is reading. The bench provokes this by raising `cfg_load` and `req_valid` on one falling edge for a block whose old and new settings give opposite verdicts. It expects the verdict of the old setting, and then checks that a follow-up request gets the verdict of the new one. Randomised traffic also mixes loads and requests to other blocks in the same cycles, and each verdict is compared with a model that tests region membership by address masking rather than by range comparison.

// File: rtl/nvm_guard_pkg.sv
package nvm_guard_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'b00,
    OP_SECT = 2'b01,
    OP_MASS = 2'b10,
    OP_BAD  = 2'b11
  } guard_op_e;

  typedef struct packed {
    logic       open;
    logic       rsvd;
    logic       hi_off;
    logic [1:0] hi_code;
    logic       lo_off;
    logic [1:0] lo_code;
  } guard_cfg_t;

  localparam guard_cfg_t CFG_LOCKED = '0;

  // Region length in bytes for a size code on top of the smallest size.
  function automatic int unsigned region_bytes(input int unsigned min_log2,
                                               input logic [1:0] code);
    return 32'd1 << (min_log2 + 32'(code));
  endfunction

  // Region anchored at base, growing upward.
  function automatic logic in_rising(input int unsigned a,
                                     input int unsigned base,
                                     input int unsigned len);
    return (a >= base) && (a < base + len);
  endfunction

  // Region anchored at the window end, growing downward.
  function automatic logic in_falling(input int unsigned a,
                                      input int unsigned top,
                                      input int unsigned len);
    return (a >= top - len) && (a < top);
  endfunction

  function automatic int unsigned align_down(input int unsigned a,
                                             input int unsigned log2);
    return (a >> log2) << log2;
  endfunction

endpackage

// File: rtl/nvm_guard_bank.sv
module nvm_guard_bank
  import nvm_guard_pkg::*;
#(
  parameter int NUM_BLOCKS = 4,
  parameter int BLK_W      = $clog2(NUM_BLOCKS)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             ld,
  input  logic [BLK_W-1:0]                 ld_slot,
  input  logic [7:0]                       ld_byte,
  output guard_cfg_t [NUM_BLOCKS-1:0]      cfg_q
);

  guard_cfg_t ld_cfg;
  logic       unused_rsvd;

  always_comb begin
    ld_cfg      = guard_cfg_t'(ld_byte);
    ld_cfg.rsvd = 1'b0;
  end
  assign unused_rsvd = ld_byte[6];

  for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_blk
    localparam int SLOT = NUM_BLOCKS - 1 - g;
    logic slot_hit;
    assign slot_hit = ld && (ld_slot == BLK_W'(SLOT));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cfg_q[g] <= CFG_LOCKED;
      else if (slot_hit) cfg_q[g] <= ld_cfg;
    end
  end

endmodule

// File: rtl/nvm_guard_eval.sv
module nvm_guard_eval
  import nvm_guard_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int LO_MIN_LOG2 = 9,
  parameter int HI_MIN_LOG2 = 11,
  parameter int SECT_LOG2   = 9
) (
  input  guard_cfg_t        cfg,
  input  logic [1:0]        op,
  input  logic [ADDR_W-1:0] addr,
  output logic              whole_locked,
  output logic              hit_low,
  output logic              hit_high,
  output logic              any_prot,
  output logic              refuse
);

  localparam int unsigned WIN_TOP = 32'd1 << ADDR_W;
  localparam int unsigned LO_BASE = 32'd1 << (ADDR_W - 1);

  guard_op_e   op_e;
  int unsigned probe;

  always_comb begin
    op_e = guard_op_e'(op);
    case (op_e)
      OP_PROG: probe = align_down(32'(addr), 1);
      OP_SECT: probe = align_down(32'(addr), SECT_LOG2);
      default: probe = 32'(addr);
    endcase
  end

  assign whole_locked = !cfg.open;
  assign any_prot     = !cfg.lo_off || !cfg.hi_off;
  assign hit_low      = !cfg.lo_off &&
                        in_rising(probe, LO_BASE, region_bytes(LO_MIN_LOG2, cfg.lo_code));
  assign hit_high     = !cfg.hi_off &&
                        in_falling(probe, WIN_TOP, region_bytes(HI_MIN_LOG2, cfg.hi_code));

  always_comb begin
    case (op_e)
      OP_PROG, OP_SECT: refuse = whole_locked || hit_low || hit_high;
      OP_MASS:          refuse = whole_locked || any_prot;
      default:          refuse = 1'b1;
    endcase
  end

endmodule

// File: rtl/nvm_range_guard.sv
module nvm_range_guard
  import nvm_guard_pkg::*;
#(
  parameter int NUM_BLOCKS  = 4,
  parameter int ADDR_W      = 16,
  parameter int LO_MIN_LOG2 = 9,
  parameter int HI_MIN_LOG2 = 11,
  parameter int SECT_LOG2   = 9,
  localparam int BLK_W      = $clog2(NUM_BLOCKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [BLK_W-1:0]  cfg_slot,
  input  logic [7:0]        cfg_byte,
  input  logic              req_valid,
  input  logic [BLK_W-1:0]  req_block,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              chk_done,
  output logic              chk_viol
);

  guard_cfg_t [NUM_BLOCKS-1:0] cfg_q;
  guard_cfg_t                  sel_cfg;
  logic whole_locked, hit_low, hit_high, any_prot, refuse;

  nvm_guard_bank #(
    .NUM_BLOCKS (NUM_BLOCKS),
    .BLK_W      (BLK_W)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld      (cfg_load),
    .ld_slot (cfg_slot),
    .ld_byte (cfg_byte),
    .cfg_q   (cfg_q)
  );

  if (NUM_BLOCKS == (1 << BLK_W)) begin : g_sel_full
    assign sel_cfg = cfg_q[req_block];
  end else begin : g_sel_part
    always_comb begin
      if (32'(req_block) < NUM_BLOCKS) sel_cfg = cfg_q[req_block];
      else                             sel_cfg = CFG_LOCKED;
    end
  end

  nvm_guard_eval #(
    .ADDR_W      (ADDR_W),
    .LO_MIN_LOG2 (LO_MIN_LOG2),
    .HI_MIN_LOG2 (HI_MIN_LOG2),
    .SECT_LOG2   (SECT_LOG2)
  ) u_eval (
    .cfg          (sel_cfg),
    .op           (req_op),
    .addr         (req_addr),
    .whole_locked (whole_locked),
    .hit_low      (hit_low),
    .hit_high     (hit_high),
    .any_prot     (any_prot),
    .refuse       (refuse)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_done <= 1'b0;
      chk_viol <= 1'b0;
    end else begin
      chk_done <= req_valid;
      chk_viol <= req_valid && refuse;
    end
  end

endmodule

// File: rtl/nvm_range_guard_chk.sv
module nvm_range_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [1:0] req_op,
  input logic       chk_done,
  input logic       chk_viol,
  input logic       whole_locked,
  input logic       hit_low,
  input logic       hit_high,
  input logic       any_prot
);

  // R2
  done_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> chk_done);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!chk_done && !chk_viol));

  // R4
  locked_refuses_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && whole_locked) |=> chk_viol);

  // R8
  mass_guarded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'b10 && any_prot) |=> chk_viol);

  // R9
  bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'b11) |=> chk_viol);

  // R5
  // R6
  free_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op[1] == 1'b0 && !whole_locked && !hit_low && !hit_high)
      |=> !chk_viol);

endmodule

bind nvm_range_guard nvm_range_guard_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_op       (req_op),
  .chk_done     (chk_done),
  .chk_viol     (chk_viol),
  .whole_locked (whole_locked),
  .hit_low      (hit_low),
  .hit_high     (hit_high),
  .any_prot     (any_prot)
);

// File: tb/test_nvm_range_guard.sv
`timescale 1ns/1ps
module test_nvm_range_guard;

  localparam int NB = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0;
  logic [1:0]  cfg_slot = '0;
  logic [7:0]  cfg_byte = '0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_block = '0;
  logic [1:0]  req_op = '0;
  logic [15:0] req_addr = '0;
  logic        chk_done, chk_viol;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] model [NB];
  bit finished = 0;

  always #2.5 clk = ~clk;

  nvm_range_guard i_nvm_range_guard (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_slot(cfg_slot),
    .cfg_byte(cfg_byte), .req_valid(req_valid), .req_block(req_block),
    .req_op(req_op), .req_addr(req_addr), .chk_done(chk_done), .chk_viol(chk_viol)
  );

  // Membership by masking: low region shares the upper address bits with 0x8000,
  // high region has all bits above its size set.
  function automatic bit exp_refuse(input logic [7:0] c, input logic [1:0] op,
                                    input logic [15:0] a);
    logic [15:0] lo_mask, hi_keep, p;
    bit lo_en, hi_en;
    if (op == 2'b11) return 1;
    if (!c[7]) return 1;
    lo_en = !c[2];
    hi_en = !c[5];
    if (op == 2'b10) return lo_en || hi_en;
    p = (op == 2'b00) ? (a & 16'hFFFE) : (a & 16'hFE00);
    lo_mask = 16'hFFFF << (9 + c[1:0]);
    hi_keep = ~(16'hFFFF << (11 + c[4:3]));
    return (lo_en && ((p & lo_mask) == 16'h8000)) ||
           (hi_en && ((p | hi_keep) == 16'hFFFF));
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic do_load(input int slot, input logic [7:0] b);
    @(negedge clk);
    cfg_load = 1'b1; cfg_slot = 2'(slot); cfg_byte = b;
    @(negedge clk);
    cfg_load = 1'b0;
    model[NB-1-slot] = b;
  endtask

  task automatic do_req(input string tag, input int blk, input logic [1:0] op,
                        input logic [15:0] a);
    bit e;
    e = exp_refuse(model[blk], op, a);
    @(negedge clk);
    req_valid = 1'b1; req_block = 2'(blk); req_op = op; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " R2 done"}, chk_done, 1'b1);
    check(tag, chk_viol, e);
  endtask

  // Load and request in the same cycle; verdict from the old setting.
  task automatic do_both(input string tag, input int slot, input logic [7:0] b,
                         input int blk, input logic [1:0] op, input logic [15:0] a);
    bit e;
    e = exp_refuse(model[blk], op, a);
    @(negedge clk);
    cfg_load = 1'b1; cfg_slot = 2'(slot); cfg_byte = b;
    req_valid = 1'b1; req_block = 2'(blk); req_op = op; req_addr = a;
    @(negedge clk);
    cfg_load = 1'b0; req_valid = 1'b0;
    model[NB-1-slot] = b;
    check({tag, " R2 done"}, chk_done, 1'b1);
    check(tag, chk_viol, e);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4177));
    for (int i = 0; i < NB; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    check("R1 done at reset", chk_done, 1'b0);
    check("R1 viol at reset", chk_viol, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 done after reset", chk_done, 1'b0);
    do_req("R1 unloaded block locked", 2, 2'b00, 16'h4000);
    @(negedge clk);
    check("R2 idle done", chk_done, 1'b0);
    check("R2 idle viol", chk_viol, 1'b0);

    // R6 / R7 low region 512 B
    do_load(3, 8'hA0);
    do_req("R6 low 512 inside", 0, 2'b00, 16'h81FF);
    do_req("R6 low 512 above", 0, 2'b00, 16'h8200);
    do_req("R7 sector base in low", 0, 2'b01, 16'h81FF);
    do_req("R6 below low region", 0, 2'b00, 16'h7FFE);
    do_load(3, 8'hA3);
    do_req("R6 low 4K top", 0, 2'b00, 16'h8FFE);
    do_req("R6 low 4K past", 0, 2'b01, 16'h9000);
    // R5 high region
    do_load(3, 8'h84);
    do_req("R5 high 2K start", 0, 2'b00, 16'hF800);
    do_req("R5 high 2K below", 0, 2'b00, 16'hF7FE);
    do_load(3, 8'h9C);
    do_req("R5 high 16K start", 0, 2'b01, 16'hC000);
    do_req("R5 high 16K below", 0, 2'b01, 16'hBFFF);
    do_req("R6 low off ignored", 0, 2'b00, 16'h8000);
    // R4 locked ignores fields
    do_load(3, 8'h24);
    do_req("R4 locked low addr", 0, 2'b00, 16'h0000);
    do_req("R4 locked mass", 0, 2'b10, 16'h0000);
    // R8 mass erase
    do_load(3, 8'hA4);
    do_req("R8 mass allowed", 0, 2'b10, 16'h1234);
    do_load(3, 8'hE4);
    do_req("R3 bit6 no effect", 0, 2'b10, 16'h1234);
    do_load(3, 8'h84);
    do_req("R8 mass high on", 0, 2'b10, 16'h0000);
    // R9
    do_load(3, 8'hA4);
    do_req("R9 undefined op", 0, 2'b11, 16'h1000);
    // R3 slot mapping
    do_load(0, 8'hA4);
    do_req("R3 slot0 feeds block3", 3, 2'b00, 16'h8000);
    do_req("R3 block1 untouched", 1, 2'b00, 16'h1000);
    do_req("R3 block0 kept", 0, 2'b10, 16'h0000);
    // R10 simultaneous load and check
    do_both("R10 old setting used", 2, 8'hA4, 1, 2'b00, 16'h1000);
    do_req("R10 new setting next", 1, 2'b00, 16'h1000);
    do_both("R10 old open used", 2, 8'h00, 1, 2'b10, 16'h0000);
    do_req("R10 new lock next", 1, 2'b10, 16'h0000);

    // Random mix
    for (int k = 0; k < 600; k++) begin
      int sel;
      logic [15:0] a;
      logic [7:0] b;
      sel = int'($urandom_range(0, 9));
      b = 8'($urandom);
      a = 16'($urandom);
      if ($urandom_range(0, 3) != 0) a[15] = 1'b1;
      if (sel < 2) do_load(int'($urandom_range(0, 3)), b);
      else if (sel < 3)
        do_both("R10 random", int'($urandom_range(0, 3)), b,
                int'($urandom_range(0, 3)), 2'($urandom), a);
      else
        do_req("R5 R6 R7 R8 random", int'($urandom_range(0, 3)), 2'($urandom), a);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule